// File: doc/BRIEF.md
# Video Gain Control Loop

This block applies a digital gain to a stream of 10-bit composite video samples and adjusts that gain once per video line. The adjustment compares up to four per-line amplitude measurements with programmed targets. The four measurements are sync height, colour burst amplitude, composite peak and luma peak. Each one arrives with a valid pulse from logic outside the block. A mask picks which measurements take part. Raising and lowering the gain are handled separately: each direction has its own step size and its own hold-off. The hold-off is the number of consecutive lines the request must persist before any step is taken.

The gain word is unsigned fixed point, with 2 integer bits and 12 fraction bits. The value 4096 means unity. The gain is always kept between a minimum code and a maximum code. Each sample is multiplied by the gain and the fraction bits are dropped. The result is clipped to 1023 and presented one clock later. When the loop is switched off, the gain stays frozen at its present value.

Top module: `vgl_top`

## Requirements
- R1: After reset, `gain` is 4096, `out_valid` is 0 and `sample_out` is 0.
- R2: One clock after a cycle with `sample_valid` high, `out_valid` is 1 and `sample_out` equals min(floor(sample_in × gain / 4096), 1023). `out_valid` is 0 one clock after a cycle with `sample_valid` low.
- R3: Measurement bit positions are: 0 for sync height, 1 for burst, 2 for composite peak and 3 for luma peak. At each `line_end`, the line asks for a decrease if any masked measurement captured in that line is strictly above its target. Otherwise it asks for an increase only if every masked measurement was captured and is strictly below its target. In every other case, including an empty mask, it asks for nothing.
- R4: A measurement counts for the line whose `line_end` follows it. A valid pulse in the same cycle as `line_end` belongs to the next line. Captured results are cleared by `line_end`, and a later pulse for the same measurement replaces the earlier one.
- R5: The gain rises by `cfg_up_step` at a `line_end` where the increase request has persisted for more than `cfg_up_delay` consecutive line ends, counting the current one.
- R6: The gain falls by `cfg_dn_step` at a `line_end` where the decrease request has persisted for more than `cfg_dn_delay` consecutive line ends, counting the current one.
- R7: The count of consecutive line ends restarts at 1 when the request changes direction. It is cleared by a line with no request and while the loop is disabled.
- R8: The gain never leaves the range GAIN_MIN to GAIN_MAX. With the default parameters this is 1024 to 12288. A step that would cross a bound lands exactly on that bound.
- R9: The gain changes only at a `line_end` while `cfg_enable` is high. When `cfg_enable` is low the gain holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Loop enable |
| cfg_ref_mask | input | 4 | Measurements taking part (bit order as in R3) |
| cfg_target | input | 40 | Four 10-bit targets, measurement i at bits [10i+9:10i] |
| cfg_up_step | input | 14 | Gain increment per step |
| cfg_up_delay | input | 8 | Lines of hold-off before increasing |
| cfg_dn_step | input | 14 | Gain decrement per step |
| cfg_dn_delay | input | 8 | Lines of hold-off before decreasing |
| meas_value | input | 40 | Four 10-bit measurements, same packing as targets |
| meas_valid | input | 4 | Per-measurement valid pulse |
| line_end | input | 1 | End-of-line strobe, one cycle |
| sample_in | input | 10 | Video sample |
| sample_valid | input | 1 | Sample qualifier |
| sample_out | output | 10 | Scaled, clipped sample |
| out_valid | output | 1 | Output qualifier |
| gain | output | 14 | Current gain, 2.12 unsigned |

## Verification
The hardest state to reach from the ports is a step that fires exactly on the line where the persistence count first exceeds its hold-off. The count is hidden, and it restarts whenever the request changes direction or lapses. To reach it, the bench runs hundreds of lines with pseudo-random masks, valid patterns, measurement values near the targets, hold-offs of zero to three lines, and occasional disabled lines. It mirrors the count in a reference model and compares the gain after every line. Directed runs drive the gain hard into both bounds, and full 1024-sample sweeps at several reached gains cover the clipping of the product.

// File: rtl/vgl_pkg.sv
package vgl_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_UP   = 2'd1,
    REQ_DN   = 2'd2
  } req_e;
endpackage

// File: rtl/vgl_ref_judge.sv
module vgl_ref_judge #(
  parameter int NUM_REF = 4,
  parameter int REF_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REF-1:0]       ref_mask,
  input  logic [NUM_REF*REF_W-1:0] target,
  input  logic [NUM_REF*REF_W-1:0] value,
  input  logic [NUM_REF-1:0]       valid,
  input  logic                     line_end,
  output logic                     req_up,
  output logic                     req_dn
);
  logic [NUM_REF-1:0] seen_q, seen_d;
  logic [NUM_REF-1:0] high_q, high_d;
  logic [NUM_REF-1:0] low_q,  low_d;

  for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
    logic [REF_W-1:0] v, t;
    assign v = value[i*REF_W +: REF_W];
    assign t = target[i*REF_W +: REF_W];
    always_comb begin
      seen_d[i] = seen_q[i];
      high_d[i] = high_q[i];
      low_d[i]  = low_q[i];
      if (line_end) begin
        seen_d[i] = 1'b0;
        high_d[i] = 1'b0;
        low_d[i]  = 1'b0;
      end
      if (valid[i]) begin
        seen_d[i] = 1'b1;
        high_d[i] = (v > t);
        low_d[i]  = (v < t);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      high_q <= '0;
      low_q  <= '0;
    end else begin
      seen_q <= seen_d;
      high_q <= high_d;
      low_q  <= low_d;
    end
  end

  assign req_dn = |(ref_mask & seen_q & high_q);
  assign req_up = (|ref_mask) && (&(~ref_mask | (seen_q & low_q)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && (valid == '0)) |=> (seen_q == '0));
endmodule

// File: rtl/vgl_gain_ctrl.sv
module vgl_gain_ctrl
  import vgl_pkg::*;
#(
  parameter int GAIN_W    = 14,
  parameter int FRAC_W    = 12,
  parameter int CNT_W     = 8,
  parameter int GAIN_MIN  = 1024,
  parameter int GAIN_MAX  = 12288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              line_end,
  input  logic              req_up,
  input  logic              req_dn,
  input  logic [GAIN_W-1:0] up_step,
  input  logic [CNT_W-1:0]  up_delay,
  input  logic [GAIN_W-1:0] dn_step,
  input  logic [CNT_W-1:0]  dn_delay,
  output logic [GAIN_W-1:0] gain
);
  localparam int GW1 = GAIN_W + 1;
  localparam int RUN_W = CNT_W + 1;
  localparam logic [GW1-1:0] G_MIN = GW1'(GAIN_MIN);
  localparam logic [GW1-1:0] G_MAX = GW1'(GAIN_MAX);
  localparam logic [GAIN_W-1:0] G_UNITY = GAIN_W'(1 << FRAC_W);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  req_e             dir_q, dir_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic [GW1-1:0]   up_sum, dn_floor;

  assign up_sum   = {1'b0, gain_q} + {1'b0, up_step};
  assign dn_floor = {1'b0, dn_step} + G_MIN;

  always_comb begin
    dir_d  = dir_q;
    run_d  = run_q;
    gain_d = gain_q;
    if (!enable) begin
      dir_d = REQ_NONE;
      run_d = '0;
    end else if (line_end) begin
      dir_d = req_dn ? REQ_DN : (req_up ? REQ_UP : REQ_NONE);
      if (dir_d == REQ_NONE)      run_d = '0;
      else if (dir_d != dir_q)    run_d = RUN_W'(1);
      else if (run_q != RUN_MAX)  run_d = run_q + RUN_W'(1);
      if (dir_d == REQ_UP && run_d > {1'b0, up_delay}) begin
        gain_d = (up_sum > G_MAX) ? G_MAX[GAIN_W-1:0] : up_sum[GAIN_W-1:0];
      end else if (dir_d == REQ_DN && run_d > {1'b0, dn_delay}) begin
        gain_d = ({1'b0, gain_q} < dn_floor) ? G_MIN[GAIN_W-1:0] : gain_q - dn_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= REQ_NONE;
      run_q  <= '0;
      gain_q <= G_UNITY;
    end else begin
      dir_q  <= dir_d;
      run_q  <= run_d;
      gain_q <= gain_d;
    end
  end

  assign gain = gain_q;

  assert_gain_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, gain_q} >= G_MIN) && ({1'b0, gain_q} <= G_MAX));
  assert_gain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_end && enable) |=> $stable(gain_q));
  assert_dn_never_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && enable && req_dn) |=> (gain_q <= $past(gain_q)));
  assert_up_never_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && enable && req_up && !req_dn) |=> (gain_q >= $past(gain_q)));
endmodule

// File: rtl/vgl_scaler.sv
module vgl_scaler #(
  parameter int SAMPLE_W = 10,
  parameter int GAIN_W   = 14,
  parameter int FRAC_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                sample_valid,
  input  logic [GAIN_W-1:0]   gain,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                out_valid
);
  localparam int PROD_W = SAMPLE_W + GAIN_W;
  localparam int SHR_W  = PROD_W - FRAC_W;

  logic [PROD_W-1:0]   prod;
  logic [SHR_W-1:0]    scaled;
  logic [SAMPLE_W-1:0] clip_d, out_q;
  logic                vld_q;

  assign prod   = PROD_W'(sample_in) * PROD_W'(gain);
  assign scaled = prod[PROD_W-1:FRAC_W];

  always_comb begin
    if (scaled > SHR_W'({SAMPLE_W{1'b1}})) clip_d = {SAMPLE_W{1'b1}};
    else                                    clip_d = scaled[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= sample_valid;
      if (sample_valid) out_q <= clip_d;
    end
  end

  assign sample_out = out_q;
  assign out_valid  = vld_q;

  assert_out_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> out_valid);
  assert_out_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !out_valid);
endmodule

// File: rtl/vgl_top.sv
module vgl_top #(
  parameter int SAMPLE_W = 10,
  parameter int GAIN_W   = 14,
  parameter int FRAC_W   = 12,
  parameter int NUM_REF  = 4,
  parameter int REF_W    = 10,
  parameter int CNT_W    = 8,
  parameter int GAIN_MIN = 1024,
  parameter int GAIN_MAX = 12288
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_enable,
  input  logic [NUM_REF-1:0]       cfg_ref_mask,
  input  logic [NUM_REF*REF_W-1:0] cfg_target,
  input  logic [GAIN_W-1:0]        cfg_up_step,
  input  logic [CNT_W-1:0]         cfg_up_delay,
  input  logic [GAIN_W-1:0]        cfg_dn_step,
  input  logic [CNT_W-1:0]         cfg_dn_delay,
  input  logic [NUM_REF*REF_W-1:0] meas_value,
  input  logic [NUM_REF-1:0]       meas_valid,
  input  logic                     line_end,
  input  logic [SAMPLE_W-1:0]      sample_in,
  input  logic                     sample_valid,
  output logic [SAMPLE_W-1:0]      sample_out,
  output logic                     out_valid,
  output logic [GAIN_W-1:0]        gain
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       req_up, req_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  vgl_ref_judge #(.NUM_REF(NUM_REF), .REF_W(REF_W)) u_judge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ref_mask (cfg_ref_mask),
    .target   (cfg_target),
    .value    (meas_value),
    .valid    (meas_valid),
    .line_end (line_end),
    .req_up   (req_up),
    .req_dn   (req_dn)
  );

  vgl_gain_ctrl #(
    .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W),
    .GAIN_MIN(GAIN_MIN), .GAIN_MAX(GAIN_MAX)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable   (cfg_enable),
    .line_end (line_end),
    .req_up   (req_up),
    .req_dn   (req_dn),
    .up_step  (cfg_up_step),
    .up_delay (cfg_up_delay),
    .dn_step  (cfg_dn_step),
    .dn_delay (cfg_dn_delay),
    .gain     (gain)
  );

  vgl_scaler #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_scale (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sample_in    (sample_in),
    .sample_valid (sample_valid),
    .gain         (gain),
    .sample_out   (sample_out),
    .out_valid    (out_valid)
  );
endmodule

// File: tb/tb_vgl_top.sv
`timescale 1ns/1ps
module tb_vgl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable;
  logic [3:0]  cfg_ref_mask;
  logic [39:0] cfg_target;
  logic [13:0] cfg_up_step, cfg_dn_step;
  logic [7:0]  cfg_up_delay, cfg_dn_delay;
  logic [39:0] meas_value;
  logic [3:0]  meas_valid;
  logic        line_end;
  logic [9:0]  sample_in;
  logic        sample_valid;
  logic [9:0]  sample_out;
  logic        out_valid;
  logic [13:0] gain;

  int n_chk = 0, n_bad = 0;
  int m_gain, m_dir, m_run;
  logic [3:0] f_seen, f_high, f_low;
  localparam int TGT = 500;

  always #2.5 clk = ~clk;

  vgl_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ref_mask(cfg_ref_mask),
    .cfg_target(cfg_target), .cfg_up_step(cfg_up_step), .cfg_up_delay(cfg_up_delay),
    .cfg_dn_step(cfg_dn_step), .cfg_dn_delay(cfg_dn_delay), .meas_value(meas_value),
    .meas_valid(meas_valid), .line_end(line_end), .sample_in(sample_in),
    .sample_valid(sample_valid), .sample_out(sample_out), .out_valid(out_valid), .gain(gain)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [39:0] pack4(input int a, input int b, input int c, input int d);
    return {10'(d), 10'(c), 10'(b), 10'(a)};
  endfunction

  task automatic capture(input logic [3:0] v, input logic [39:0] vals);
    for (int i = 0; i < 4; i++) if (v[i]) begin
      f_seen[i] = 1'b1;
      f_high[i] = (int'(vals[i*10 +: 10]) > TGT);
      f_low[i]  = (int'(vals[i*10 +: 10]) < TGT);
    end
  endtask

  // One video line: pulses v_pre before line_end, v_at in the line_end cycle.
  task automatic run_line(input logic [3:0] v_pre, input logic [39:0] vals_pre,
                          input logic [3:0] v_at, input logic [39:0] vals_at, input string req);
    int d, step_ok;
    if (v_pre != 4'b0) begin
      meas_valid = v_pre; meas_value = vals_pre;
      @(negedge clk);
      capture(v_pre, vals_pre);
    end
    meas_valid = v_at; meas_value = vals_at; line_end = 1'b1;
    // model of R3 / R5 / R6 / R7 / R8 / R9
    if (cfg_enable) begin
      if (|(cfg_ref_mask & f_seen & f_high)) d = 2;
      else if (cfg_ref_mask != 0 && (&(~cfg_ref_mask | (f_seen & f_low)))) d = 1;
      else d = 0;
      if (d == 0) m_run = 0;
      else if (d != m_dir) m_run = 1;
      else if (m_run < 511) m_run++;
      m_dir = d;
      step_ok = 0;
      if (d == 1 && m_run > int'(cfg_up_delay)) begin
        m_gain = m_gain + int'(cfg_up_step);
        if (m_gain > 12288) m_gain = 12288;
      end else if (d == 2 && m_run > int'(cfg_dn_delay)) begin
        m_gain = m_gain - int'(cfg_dn_step);
        if (m_gain < 1024) m_gain = 1024;
      end
    end else begin
      m_dir = 0; m_run = 0;
    end
    f_seen = 4'b0; f_high = 4'b0; f_low = 4'b0;
    @(negedge clk);
    capture(v_at, vals_at);
    meas_valid = 4'b0; line_end = 1'b0;
    check(req, int'(gain), m_gain);
  endtask

  task automatic sweep(input string req);
    int e;
    for (int s = 0; s < 1024; s++) begin
      sample_in = 10'(s); sample_valid = 1'b1;
      @(negedge clk);
      e = (s * m_gain) >> 12;
      if (e > 1023) e = 1023;
      check(req, int'(sample_out), e);
      check(req, int'(out_valid), 1);
    end
    sample_valid = 1'b0;
    @(negedge clk);
    check(req, int'(out_valid), 0);
  endtask

  initial begin
    #900000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [39:0] below, above, mixed;
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_ref_mask = 4'b0;
    cfg_target = pack4(TGT, TGT, TGT, TGT);
    cfg_up_step = 14'd0; cfg_dn_step = 14'd0; cfg_up_delay = 8'd0; cfg_dn_delay = 8'd0;
    meas_value = '0; meas_valid = 4'b0; line_end = 1'b0; sample_in = '0; sample_valid = 1'b0;
    m_gain = 4096; m_dir = 0; m_run = 0; f_seen = 0; f_high = 0; f_low = 0;
    below = pack4(400, 400, 400, 400);
    above = pack4(600, 600, 600, 600);
    mixed = pack4(400, 400, 600, 400);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 gain", int'(gain), 4096);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 sample_out", int'(sample_out), 0);
    // R2 unity gain sweep
    sweep("R2 unity");
    // R9 disabled: requests do nothing
    cfg_ref_mask = 4'b1111; cfg_up_step = 14'd100; cfg_dn_step = 14'd100;
    for (int k = 0; k < 4; k++) run_line(4'b1111, below, 4'b0, '0, "R9 disabled");
    // R5 hold-off of 2 lines on increase
    cfg_enable = 1'b1; cfg_ref_mask = 4'b0001; cfg_up_delay = 8'd2; cfg_up_step = 14'd300;
    for (int k = 0; k < 5; k++) run_line(4'b0001, below, 4'b0, '0, "R5 up hold-off");
    // R3 unmasked ref above is ignored
    run_line(4'b0101, mixed, 4'b0, '0, "R3 unmasked ignored");
    // R3 masked ref above wins, R6 delay 1
    cfg_ref_mask = 4'b0101; cfg_dn_delay = 8'd1; cfg_dn_step = 14'd250;
    for (int k = 0; k < 4; k++) run_line(4'b0101, mixed, 4'b0, '0, "R6 down priority");
    // R3 masked ref missing -> no request
    run_line(4'b0001, below, 4'b0, '0, "R3 missing ref holds");
    // R7 direction flips restart the count
    cfg_up_delay = 8'd1; cfg_dn_delay = 8'd1;
    for (int k = 0; k < 6; k++)
      run_line(4'b0101, (k % 2 == 0) ? below : above, 4'b0, '0, "R7 restart");
    // R4 pulse in line_end cycle belongs to next line
    run_line(4'b0, '0, 4'b0101, below, "R4 late pulse");
    run_line(4'b0, '0, 4'b0, '0, "R4 late pulse counted");
    run_line(4'b0, '0, 4'b0, '0, "R4 cleared");
    // R8 clamp at max
    cfg_up_delay = 8'd0; cfg_up_step = 14'd3000;
    for (int k = 0; k < 5; k++) run_line(4'b0101, below, 4'b0, '0, "R8 max clamp");
    check("R8 at max", int'(gain), 12288);
    sweep("R2 high gain");
    // R8 clamp at min
    cfg_dn_delay = 8'd0; cfg_dn_step = 14'd5000;
    for (int k = 0; k < 4; k++) run_line(4'b0101, above, 4'b0, '0, "R8 min clamp");
    check("R8 at min", int'(gain), 1024);
    sweep("R2 low gain");
    // pseudo-random lines R3 R5 R6 R7 R9
    void'($urandom(7));
    for (int k = 0; k < 600; k++) begin
      logic [39:0] vp, va;
      cfg_enable   = ($urandom % 8) != 0;
      if ($urandom % 16 == 0) begin
        cfg_ref_mask = 4'($urandom);
        cfg_up_delay = 8'($urandom % 4); cfg_dn_delay = 8'($urandom % 4);
        cfg_up_step  = 14'($urandom % 600); cfg_dn_step = 14'($urandom % 600);
      end
      vp = pack4(497 + $urandom % 6, 497 + $urandom % 6, 497 + $urandom % 6, 497 + $urandom % 6);
      va = pack4(490 + $urandom % 20, 490 + $urandom % 20, 490 + $urandom % 20, 490 + $urandom % 20);
      if ($urandom % 2 == 0) vp = pack4(480, 490, 470, 495);
      run_line(4'($urandom | 1), vp, ($urandom % 5 == 0) ? 4'($urandom) : 4'b0, va, "R3 R7 random line");
      if (k % 150 == 149) sweep("R2 random gain");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule